// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block produces an output clock from a reference clock. The division ratio comes from a 5-bit setting written through a simple write strobe with a data byte. For a nonzero setting N the output runs at the reference frequency divided by N + 2, with equal high and low times. A setting of zero routes the reference through undivided.

Only even settings are meaningful. An odd value is rounded down to the even value below it before the block uses it. A new setting does not cut into the output period that is running; it takes effect when the divided output next falls. The output is switched between the divided clock and the reference only while both are low, so the change leaves no short pulse.

Top module: `ref_clk_divider`

## Requirements
- R1: While rst_ni is low, clk_o is low. After reset the setting is 30, so clk_o goes high after the 16th rising reference edge and then stays high for 16 reference cycles and low for 16.
- R2: When the setting N (wr_data_i[4:0]) is even and nonzero, clk_o is high for N/2 + 1 reference cycles and low for N/2 + 1 reference cycles.
- R3: An odd value written to wr_data_i[4:0] is used as the value one below it. A value of 1 therefore selects pass-through.
- R4: wr_data_i[7:5] are ignored. For example, 0xA8 gives the same output as 0x08.
- R5: A setting of 0 makes clk_o follow clk_i: high while clk_i is high, low while clk_i is low.
- R6: A new setting is applied only on the falling edge of the divided output. The low and high phases already in progress finish at the old length.
- R7: The source of clk_o changes only while the divided clock is low. No high or low pulse on clk_o is shorter than half a reference period.
- R8: While wr_en_i is low, wr_data_i has no effect on clk_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the setting |
| wr_data_i | input | 8 | Write data; bits [4:0] hold the setting |
| clk_o | output | 1 | Divided or passed-through clock |

## Verification
The bench uses the default parameters: a 5-bit setting field, an 8-bit data bus and a reset setting of 30. With these values both ends of the ratio range are reachable in a short run: divide-by-4 at setting 2 and divide-by-32 at setting 30. The odd values 7 and 1 are exercised, as are writes with the upper data bits set. The run also covers writes that land in the high phase and writes that land in the low phase of a running period, and it measures every high and low pulse width on the output, including the pulses around switches into and out of pass-through.

// File: rtl/refdiv_pkg.sv
`timescale 1ns/1ps
package refdiv_pkg;
  typedef enum logic {
    SRC_DIV = 1'b0,
    SRC_REF = 1'b1
  } clk_src_e;
endpackage

// File: rtl/refdiv_cfg.sv
`timescale 1ns/1ps
module refdiv_cfg #(
  parameter int FIELD_W = 5,
  parameter int DATA_W  = 8,
  parameter int RST_DIV = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [FIELD_W-1:0] field_o
);
  localparam logic [FIELD_W-1:0] RST_EVEN = FIELD_W'(RST_DIV) & ~FIELD_W'(1);

  logic [FIELD_W-1:0] field_q;
  logic               unused_bits;

  // reserved upper bits and the LSB are dropped
  assign unused_bits = ^{wr_data_i[DATA_W-1:FIELD_W], wr_data_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) field_q <= RST_EVEN;
    else if (wr_en_i) field_q <= {wr_data_i[FIELD_W-1:1], 1'b0};
  end

  assign field_o = field_q;
endmodule

// File: rtl/refdiv_core.sv
`timescale 1ns/1ps
module refdiv_core #(
  parameter int FIELD_W = 5,
  parameter int RST_DIV = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] field_i,
  output logic [FIELD_W-1:0] act_o,
  output logic [FIELD_W-2:0] cnt_o,
  output logic               div_o
);
  localparam int CNT_W = FIELD_W - 1;
  localparam logic [FIELD_W-1:0] RST_EVEN = FIELD_W'(RST_DIV) & ~FIELD_W'(1);

  logic [FIELD_W-1:0] act_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               div_q;
  logic [CNT_W-1:0]   half_m1;

  // half period minus one: (N+2)/2 - 1 = N/2
  assign half_m1 = act_q[FIELD_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= RST_EVEN;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (act_q == '0) begin
      act_q <= field_i;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (cnt_q == half_m1) begin
      cnt_q <= '0;
      div_q <= ~div_q;
      if (div_q) act_q <= field_i;  // period ends on falling output
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o = act_q;
  assign cnt_o = cnt_q;
  assign div_o = div_q;
endmodule

// File: rtl/refdiv_sel.sv
`timescale 1ns/1ps
module refdiv_sel
  import refdiv_pkg::*;
#(
  parameter int FIELD_W = 5,
  parameter int RST_DIV = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] act_i,
  input  logic               div_i,
  output clk_src_e           src_o,
  output logic               clk_o
);
  localparam clk_src_e RST_SRC = ((RST_DIV >> 1) == 0) ? SRC_REF : SRC_DIV;

  clk_src_e src_q;

  // select moves on falling reference edge with divided clock low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= RST_SRC;
    else if (!div_i) src_q <= (act_i == '0) ? SRC_REF : SRC_DIV;
  end

  assign clk_o = (src_q == SRC_REF) ? clk_i : div_i;
  assign src_o = src_q;
endmodule

// File: rtl/ref_clk_divider.sv
`timescale 1ns/1ps
module ref_clk_divider
  import refdiv_pkg::*;
#(
  parameter int FIELD_W = 5,
  parameter int DATA_W  = 8,
  parameter int RST_DIV = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              clk_o
);
  logic [FIELD_W-1:0] field_q;
  logic [FIELD_W-1:0] act_q;
  logic [FIELD_W-2:0] cnt_q;
  logic               div_q;
  clk_src_e           src_q;

  refdiv_cfg #(.FIELD_W(FIELD_W), .DATA_W(DATA_W), .RST_DIV(RST_DIV)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .field_o   (field_q)
  );

  refdiv_core #(.FIELD_W(FIELD_W), .RST_DIV(RST_DIV)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .field_i (field_q),
    .act_o   (act_q),
    .cnt_o   (cnt_q),
    .div_o   (div_q)
  );

  refdiv_sel #(.FIELD_W(FIELD_W), .RST_DIV(RST_DIV)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_q),
    .div_i  (div_q),
    .src_o  (src_q),
    .clk_o  (clk_o)
  );
endmodule

// File: rtl/ref_clk_divider_chk.sv
`timescale 1ns/1ps
module ref_clk_divider_chk
  import refdiv_pkg::*;
#(
  parameter int FIELD_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               clk_o,
  input logic [FIELD_W-1:0] field_q,
  input logic [FIELD_W-1:0] act_q,
  input logic [FIELD_W-2:0] cnt_q,
  input logic               div_q,
  input clk_src_e           src_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_LOW: assert (clk_o == 1'b0); // R1
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q[FIELD_W-1:1]); // R2

  AST_ACT_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q[0]); // R3

  AST_DIV_IDLE_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == '0) |-> !div_q); // R5

  AST_SWAP_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_q != $past(act_q)) && ($past(act_q) != '0)) |-> ($past(div_q) && !div_q)); // R6

  AST_SRC_SWITCH_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (src_q != $past(src_q)) |-> !$past(div_q)); // R7

  AST_NO_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(field_q)); // R8
endmodule

bind ref_clk_divider ref_clk_divider_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .clk_o   (clk_o),
  .field_q (field_q),
  .act_q   (act_q),
  .cnt_q   (cnt_q),
  .div_q   (div_q),
  .src_q   (src_q)
);

// File: tb/sim_ref_clk_divider.sv
`timescale 1ns/1ps
module sim_ref_clk_divider;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       clk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    half;
    string req;
  } exp_t;
  exp_t exp_q[$];

  ref_clk_divider u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .clk_o     (clk_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic sample();
    @(posedge clk_i);
    #2;
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    do begin
      n++;
      sample();
    end while (clk_o === lvl);
  endtask

  task automatic expect_half(input int h, input string r);
    exp_t e;
    e.half = h;
    e.req  = r;
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic program_div(input logic [7:0] d, input int h, input string r);
    wr(d);
    repeat (70) @(posedge clk_i);
    expect_half(h, r);
  endtask

  // monitor: pops expected half-period lengths and measures the output
  initial begin
    exp_t cur;
    int hi, lo;
    forever begin
      wait (exp_q.size() > 0);
      cur = exp_q[0];
      if (cur.half == 0) begin
        for (int i = 0; i < 8; i++) begin
          sample();
          chk(clk_o === 1'b1, cur.req, int'(clk_o), 1);
          #5;
          chk(clk_o === 1'b0, cur.req, int'(clk_o), 0);
        end
      end else begin
        do sample(); while (clk_o !== 1'b0);
        do sample(); while (clk_o !== 1'b1);
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        chk(hi == cur.half, {cur.req, " high"}, hi, cur.half);
        chk(lo == cur.half, {cur.req, " low"}, lo, cur.half);
      end
      void'(exp_q.pop_front());
    end
  end

  // R7: no runt pulses on clk_o
  realtime t_rise = 0.0;
  realtime t_fall = 0.0;
  always @(posedge clk_o) begin
    if (rst_ni && !done) chk(($realtime - t_fall) >= 4.9, "R7 low width", int'($realtime - t_fall), 5);
    t_rise = $realtime;
  end
  always @(negedge clk_o) begin
    if (rst_ni && !done) chk(($realtime - t_rise) >= 4.9, "R7 high width", int'($realtime - t_rise), 5);
    t_fall = $realtime;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, a, b, c;
    // R1: reset state
    repeat (3) sample();
    chk(clk_o === 1'b0, "R1 reset low", int'(clk_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
    do begin
      sample();
      n++;
    end while (clk_o !== 1'b1 && n < 100);
    chk(n == 16, "R1 first rise", n, 16);
    expect_half(16, "R1");

    // R8: data without strobe
    wr_data_i = 8'h02;
    repeat (40) @(posedge clk_i);
    expect_half(16, "R8");

    // R2: even settings
    program_div(8'd2, 2, "R2");
    program_div(8'd30, 16, "R2");
    program_div(8'd12, 7, "R2");

    // R3: odd rounds down
    program_div(8'd7, 4, "R3");
    // R4: reserved bits ignored
    program_div(8'hA8, 5, "R4");

    // R5: pass-through; R3: value 1 gives pass-through
    program_div(8'd2, 2, "R2");
    program_div(8'd0, 0, "R5");
    program_div(8'd4, 3, "R7");
    program_div(8'd1, 0, "R3");
    program_div(8'hE4, 3, "R4");

    // R6: write during high phase
    program_div(8'd6, 4, "R2");
    do sample(); while (clk_o !== 1'b0);
    do sample(); while (clk_o !== 1'b1);
    fork
      wr(8'd2);
      begin
        run_len(1'b1, a);
        run_len(1'b0, b);
        run_len(1'b1, c);
      end
    join
    chk(a == 4, "R6 old high", a, 4);
    chk(b == 2, "R6 new low", b, 2);
    chk(c == 2, "R6 new high", c, 2);

    // R6: write during low phase
    program_div(8'd6, 4, "R2");
    do sample(); while (clk_o !== 1'b1);
    do sample(); while (clk_o !== 1'b0);
    fork
      wr(8'd10);
      begin
        run_len(1'b0, a);
        run_len(1'b1, b);
        run_len(1'b0, c);
      end
    join
    chk(a == 4, "R6 old low", a, 4);
    chk(b == 4, "R6 old high", b, 4);
    chk(c == 6, "R6 new low", c, 6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule